// File: doc/BRIEF.md
# Per-Pin Interrupt Detector

This block watches one bank of input pins (32 by default). It can raise an interrupt on each pin separately. Three configuration words hold one bit per pin, and together these bits choose the trigger for that pin. The trigger can be a falling edge, a rising edge, either edge, a low level or a high level. A qualifying event on a pin sets that pin's bit in a sticky status word, but only when the pin's enable bit is set.

Software clears a status bit by writing a one to it. The single interrupt line is the OR of the enabled status bits, taken through one register stage.

The block is reached through a plain synchronous register port. A write takes effect on the clock edge where `wr_en_i` is high. A read returns data one cycle after `rd_en_i`. Pin inputs must already be synchronous to `clk_i`.

Top module: `pin_irq_detector`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is 0. All-zero configuration means single falling-edge detection with every pin disabled.
- R2: The registers sit at byte offsets 0x00 (enable), 0x04 (type bit 0), 0x08 (type bit 1), 0x0C (type bit 2) and 0x10 (status). A read of an offset returns its register one cycle after `rd_en_i`.
- R3: With type bit 1 = 0 and type bit 2 = 0, a pin is edge-triggered. Type bit 0 = 1 selects a rising edge (previous cycle 0, current 1), and type bit 0 = 0 selects a falling edge.
- R4: With type bit 1 = 0 and type bit 2 = 1, both edges trigger, whatever type bit 0 holds.
- R5: With type bit 1 = 1, a pin is level-triggered, and type bit 2 has no effect. Type bit 0 = 1 makes a high level active and 0 makes a low level active. The status bit is set again on every cycle the active level is present, including the cycle of a clear.
- R6: A status bit becomes set only when the pin's enable bit is 1 in the cycle of the event. Events on disabled pins are lost and do not appear when the pin is enabled later.
- R7: Writing to the status offset clears each status bit whose data bit is 1 and leaves bits written with 0 unchanged. Status bits never clear by themselves.
- R8: When a trigger event and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R9: `irq_o` equals the OR over all pins of (status AND enable) as it was one cycle earlier. It follows a status bit being set, or an enable bit being changed, by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pin_i | input | NPINS | Pin levels, synchronous to clk_i |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | NPINS | Write data |
| rdata_o | output | NPINS | Read data, valid the cycle after rd_en_i |
| irq_o | output | 1 | Combined interrupt, registered |

## Verification
The bench builds the block with the default 32 pins and a 5-bit offset. At that size the status offset 0x10 uses the top address bit.

The mode table drives all 32 pins with the same waveform, so every lane sees each trigger type. The directed tests use mixed patterns such as 0xA5A5A5A5 and single pins, and these expose a swapped or stuck lane in the detection, clearing and masking paths.

Both edges of a transition are reachable at that width. The same-cycle clear collision is also reachable on a pin in the upper half-word.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  // Byte offsets of the register bank; software decodes these.
  localparam logic [4:0] OFF_ENABLE = 5'h00;
  localparam logic [4:0] OFF_TYPE0  = 5'h04;
  localparam logic [4:0] OFF_TYPE1  = 5'h08;
  localparam logic [4:0] OFF_TYPE2  = 5'h0C;
  localparam logic [4:0] OFF_STATUS = 5'h10;

  // Configuration words, in offset order (offset = index * 4).
  typedef enum logic [1:0] {
    CFG_ENABLE = 2'd0,
    CFG_TYPE0  = 2'd1,
    CFG_TYPE1  = 2'd2,
    CFG_TYPE2  = 2'd3
  } cfg_sel_e;

  localparam int CFG_WORDS = 4;

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPINS-1:0]  wdata_i,
  output logic [NPINS-1:0]  en_o,
  output logic [NPINS-1:0]  t0_o,
  output logic [NPINS-1:0]  t1_o,
  output logic [NPINS-1:0]  t2_o
);
  import pin_irq_pkg::*;

  logic [NPINS-1:0] cfg_q [CFG_WORDS];

  // One register word per configuration field, decoded by offset.
  for (genvar k = 0; k < CFG_WORDS; k++) begin : g_cfg
    localparam logic [ADDR_W-1:0] MY_OFF = ADDR_W'(k * 4);
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        cfg_q[k] <= '0;
      end else if (wr_en_i && (addr_i == MY_OFF)) begin
        cfg_q[k] <= wdata_i;
      end
    end
  end

  assign en_o = cfg_q[CFG_ENABLE];
  assign t0_o = cfg_q[CFG_TYPE0];
  assign t1_o = cfg_q[CFG_TYPE1];
  assign t2_o = cfg_q[CFG_TYPE2];

endmodule

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] en_i,
  input  logic [NPINS-1:0] t0_i,
  input  logic [NPINS-1:0] t1_i,
  input  logic [NPINS-1:0] t2_i,
  output logic [NPINS-1:0] evt_o
);

  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) prev_q <= '0;
    else       prev_q <= pin_i;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic rise, fall, edge_hit, lvl_hit;
    always_comb begin
      rise     = pin_i[i] & ~prev_q[i];
      fall     = ~pin_i[i] & prev_q[i];
      // type bit 2 widens edge mode to both edges
      edge_hit = t2_i[i] ? (rise | fall) : (t0_i[i] ? rise : fall);
      // type bit 0 is the active level in level mode
      lvl_hit  = t0_i[i] ? pin_i[i] : ~pin_i[i];
      evt_o[i] = en_i[i] & (t1_i[i] ? lvl_hit : edge_hit);
    end
  end

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPINS-1:0]  wdata_i,
  input  logic [NPINS-1:0]  evt_i,
  input  logic [NPINS-1:0]  en_i,
  output logic [NPINS-1:0]  status_o,
  output logic              irq_o
);
  import pin_irq_pkg::*;

  localparam logic [ADDR_W-1:0] STAT_OFF = ADDR_W'(OFF_STATUS);

  logic [NPINS-1:0] status_q;
  logic [NPINS-1:0] clr_mask;
  logic             irq_q;

  always_comb begin
    clr_mask = (wr_en_i && (addr_i == STAT_OFF)) ? wdata_i : '0;
  end

  // New events are ORed after the clear, so an event wins a collision.
  always_ff @(posedge clk_i) begin
    if (rst_i) status_q <= '0;
    else       status_q <= (status_q & ~clr_mask) | evt_i;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) irq_q <= 1'b0;
    else       irq_q <= |(status_q & en_i);
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;

endmodule

// File: rtl/pin_irq_detector.sv
module pin_irq_detector #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [NPINS-1:0]  pin_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPINS-1:0]  wdata_i,
  output logic [NPINS-1:0]  rdata_o,
  output logic              irq_o
);
  import pin_irq_pkg::*;

  logic [NPINS-1:0] en_q, t0_q, t1_q, t2_q;
  logic [NPINS-1:0] evt;
  logic [NPINS-1:0] status_q;
  logic [NPINS-1:0] rd_mux;
  logic [NPINS-1:0] rdata_q;

  irq_cfg_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .wr_en_i(wr_en_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .en_o   (en_q),
    .t0_o   (t0_q),
    .t1_o   (t1_q),
    .t2_o   (t2_q)
  );

  irq_edge_detect #(.NPINS(NPINS)) u_det (
    .clk_i(clk_i),
    .rst_i(rst_i),
    .pin_i(pin_i),
    .en_i (en_q),
    .t0_i (t0_q),
    .t1_i (t1_q),
    .t2_i (t2_q),
    .evt_o(evt)
  );

  irq_status_reg #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_stat (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .evt_i   (evt),
    .en_i    (en_q),
    .status_o(status_q),
    .irq_o   (irq_o)
  );

  always_comb begin
    case (addr_i)
      ADDR_W'(OFF_ENABLE): rd_mux = en_q;
      ADDR_W'(OFF_TYPE0):  rd_mux = t0_q;
      ADDR_W'(OFF_TYPE1):  rd_mux = t1_q;
      ADDR_W'(OFF_TYPE2):  rd_mux = t2_q;
      ADDR_W'(OFF_STATUS): rd_mux = status_q;
      default:             rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)        rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/pin_irq_detector_chk.sv
module pin_irq_detector_chk #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [NPINS-1:0]  wdata_i,
  input logic [NPINS-1:0]  en_q,
  input logic [NPINS-1:0]  evt,
  input logic [NPINS-1:0]  status_q,
  input logic              irq_o
);
  logic [NPINS-1:0] clr_req;
  assign clr_req = (wr_en_i && addr_i == ADDR_W'(5'h10)) ? wdata_i : '0;

  AST_IRQ_LATENCY: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_o == |($past(status_q & en_q))); // R9

  AST_SET_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (rst_i)
    (status_q & ~$past(status_q) & ~$past(en_q)) == '0); // R6

  AST_EVENT_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(evt) & ~status_q) == '0); // R8

  AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(clr_req & ~evt) & status_q) == '0); // R7

  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(status_q) & ~status_q & ~$past(clr_req)) == '0); // R7

endmodule

bind pin_irq_detector pin_irq_detector_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .en_q    (en_q),
  .evt     (evt),
  .status_q(status_q),
  .irq_o   (irq_o)
);

// File: tb/pin_irq_detector_tb.sv
module pin_irq_detector_tb;
  localparam int NPINS  = 32;
  localparam int ADDR_W = 5;
  localparam logic [4:0] A_EN = 5'h00, A_T0 = 5'h04, A_T1 = 5'h08,
                         A_T2 = 5'h0C, A_ST = 5'h10;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  // Row: {t2, t1, t0, pin_before, pin_after, expected}
  localparam int NROWS = 16;
  localparam logic [5:0] VEC [NROWS] = '{
    6'b000101, 6'b000010, 6'b000110, 6'b001011,
    6'b001100, 6'b100011, 6'b100101, 6'b100000,
    6'b101101, 6'b101110, 6'b010110, 6'b010101,
    6'b011000, 6'b011011, 6'b110101, 6'b111111
  };

  logic              clk = 1'b0;
  logic              rst;
  logic [NPINS-1:0]  pins;
  logic              wr_en, rd_en;
  logic [ADDR_W-1:0] addr;
  logic [NPINS-1:0]  wdata;
  logic [NPINS-1:0]  rdata;
  logic              irq;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pin_irq_detector #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_dut (
    .clk_i(clk), .rst_i(rst), .pin_i(pins), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst = 1'b1; pins = '0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    idle(4);
    rst = 1'b0;
    idle(1);

    // R1: reset state
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    rd(A_EN, v); chk("R1 enable reset", v, 32'd0);
    rd(A_T0, v); chk("R1 type0 reset", v, 32'd0);
    rd(A_T1, v); chk("R1 type1 reset", v, 32'd0);
    rd(A_T2, v); chk("R1 type2 reset", v, 32'd0);
    rd(A_ST, v); chk("R1 status reset", v, 32'd0);

    // R2: readback at each offset
    wr(A_EN, 32'h1234_5678); wr(A_T0, 32'h0F0F_0F0F);
    wr(A_T1, 32'h00FF_00FF); wr(A_T2, 32'h3333_3333);
    rd(A_EN, v); chk("R2 enable readback", v, 32'h1234_5678);
    rd(A_T0, v); chk("R2 type0 readback", v, 32'h0F0F_0F0F);
    rd(A_T1, v); chk("R2 type1 readback", v, 32'h00FF_00FF);
    rd(A_T2, v); chk("R2 type2 readback", v, 32'h3333_3333);

    // Mode table: R3 edges, R4 both edges, R5 levels
    for (int r = 0; r < NROWS; r++) begin
      logic [5:0] row;
      string tag;
      row = VEC[r];
      tag = row[4] ? "R5 level mode" : (row[5] ? "R4 both edges" : "R3 single edge");
      @(negedge clk); pins = {NPINS{row[2]}};
      wr(A_T0, {32{row[3]}});
      wr(A_T1, {32{row[4]}});
      wr(A_T2, {32{row[5]}});
      wr(A_EN, ONES);
      idle(2);
      wr(A_ST, ONES);
      @(negedge clk); pins = {NPINS{row[1]}};
      idle(2);
      rd(A_ST, v);
      chk($sformatf("%s row %0d status", tag, r), v, {32{row[0]}});
      chk($sformatf("%s row %0d irq", tag, r), {31'd0, irq}, {31'd0, row[0]});
    end

    // R6: events on disabled pins are lost
    wr(A_T0, ONES); wr(A_T1, 32'd0); wr(A_T2, 32'd0); wr(A_EN, 32'd0);
    @(negedge clk); pins = '0;
    idle(2); wr(A_ST, ONES);
    @(negedge clk); pins = ONES;
    idle(2);
    rd(A_ST, v); chk("R6 disabled no status", v, 32'd0);
    chk("R6 disabled no irq", {31'd0, irq}, 32'd0);
    wr(A_EN, ONES); idle(2);
    rd(A_ST, v); chk("R6 no late status", v, 32'd0);

    // R7: write-one-to-clear, zero bits untouched
    @(negedge clk); pins = '0;
    idle(2); wr(A_ST, ONES);
    @(negedge clk); pins = 32'hA5A5_A5A5;
    idle(2);
    rd(A_ST, v); chk("R7 rising pattern set", v, 32'hA5A5_A5A5);
    wr(A_ST, 32'd0);
    rd(A_ST, v); chk("R7 write zero no change", v, 32'hA5A5_A5A5);
    wr(A_ST, 32'h0000_FFFF);
    rd(A_ST, v); chk("R7 partial clear", v, 32'hA5A5_0000);

    // R8: event and clear in the same cycle
    @(negedge clk); pins = '0;
    idle(2);
    @(negedge clk); wr_en = 1'b1; addr = A_ST; wdata = ONES; pins = 32'h0001_0000;
    @(negedge clk); wr_en = 1'b0;
    rd(A_ST, v); chk("R8 event beats clear", v, 32'h0001_0000);

    // R9: irq latency and masking by enable
    @(negedge clk); pins = '0;
    idle(2); wr(A_ST, ONES); idle(2);
    chk("R9 irq idle low", {31'd0, irq}, 32'd0);
    @(negedge clk); pins = 32'h0000_0008;
    @(negedge clk); chk("R9 irq not yet", {31'd0, irq}, 32'd0);
    @(negedge clk); chk("R9 irq one cycle later", {31'd0, irq}, 32'd1);
    wr(A_EN, 32'hFFFF_FFF7);
    @(negedge clk); chk("R9 irq masked by enable", {31'd0, irq}, 32'd0);
    rd(A_ST, v); chk("R9 status kept while masked", v, 32'h0000_0008);
    wr(A_EN, ONES);
    @(negedge clk); chk("R9 irq back on enable", {31'd0, irq}, 32'd1);

    // R5: level re-asserts through a clear
    wr(A_T0, ONES); wr(A_T1, ONES); wr(A_T2, 32'd0);
    @(negedge clk); pins = ONES;
    idle(2); wr(A_ST, ONES);
    rd(A_ST, v); chk("R5 level survives clear", v, ONES);
    @(negedge clk); pins = '0;
    wr(A_ST, ONES);
    rd(A_ST, v); chk("R5 inactive level cleared", v, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule